// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table in memory. A request carries the virtual address, a read/write flag and the base address of the root table. The walker reads a first-level entry, which points to a second-level table. It then reads the second-level (leaf) entry, which gives the physical frame number. The 12-bit page offset goes through unchanged. Only one memory request is outstanding at any time.

An entry whose valid bit is clear ends the walk with a page fault, and no physical address is returned. On a successful walk the walker keeps the leaf entry's status bits up to date. It always sets the referenced bit, and it also sets the modified bit for a write. The updated entry is written back only when one of these bits actually changes. Every walk ends with a one-cycle completion pulse that carries the result.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high only while no walk is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A `req_valid` pulse during a walk is ignored: it starts no walk, makes no memory access and does not change the result.
- R2: The first read goes to address `{root_base[31:12], va[31:22], 2'b00}`. The low 12 bits of `root_base` are ignored.
- R3: If the first-level entry is valid, the second read goes to address `{entry1[31:12], va[21:12], 2'b00}`. This holds at index extremes such as 0 and 1023.
- R4: An entry uses bit 0 as valid, bit 1 as referenced, bit 2 as modified, and bits 31:12 as a frame or table base. A successful walk returns `pa = {leaf[31:12], va[11:0]}` and `flags = leaf[2:0]`, taken after the status update.
- R5: A first-level entry with bit 0 clear ends the walk with `fault=1` and `fault_level=0`. No second read and no write take place, and `pa` and `flags` are zero.
- R6: A leaf entry with bit 0 clear ends the walk with `fault=1` and `fault_level=1`. No write takes place, and `pa` is zero.
- R7: On a read walk, a leaf with bit 1 clear is written back to the leaf address with bit 1 set. If bit 1 is already set, no write takes place.
- R8: On a write walk, the leaf is written back with bits 1 and 2 set. If both bits are already set, no write takes place.
- R9: Each accepted request produces exactly one `done` pulse, exactly one cycle long. `fault` and `fault_level` are meaningful only in that cycle.
- R10: The read and write requests are never active together. Each request stays high, with stable address and data, until its `mem_rd_valid` or `mem_wr_ack` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write (sets modified bit) |
| root_base | input | 32 | Root table base address |
| mem_rd_req | output | 1 | Entry read request, held until served |
| mem_rd_addr | output | 32 | Entry read address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Entry read data |
| mem_wr_req | output | 1 | Entry write-back request, held until acknowledged |
| mem_wr_addr | output | 32 | Write-back address |
| mem_wr_data | output | 32 | Updated entry |
| mem_wr_ack | input | 1 | Write completed |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Walk ended in a page fault |
| fault_level | output | 1 | Faulting level: 0 first, 1 second |
| pa | output | 32 | Physical address (zero on fault) |
| flags | output | 3 | Leaf status bits after update |

## Verification
Most errors in the walk state or in the captured request show up at the memory port as a wrong address. A missing access or an extra access shows up there too, within one memory latency of the fault. The bench compares every access the walker makes against the sequence that its own behavioural model predicts. A state machine that never ends a walk, or ends one twice, shows up within one cycle. In that case `req_ready` no longer matches the bench's record of an outstanding request, or `done` arrives when no walk is pending. A corrupted leaf register shows up in `pa` and `flags` in the completion cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   // status bit positions inside a table entry
   localparam int unsigned PTE_VALID_BIT = 0;
   localparam int unsigned PTE_REF_BIT   = 1;
   localparam int unsigned PTE_MOD_BIT   = 2;
   localparam int unsigned PTE_FLAG_W    = 3;
   // log2 of the entry size in bytes
   localparam int unsigned PTE_SIZE_LOG2 = 2;

   typedef enum logic [2:0] {
      WALK_IDLE  = 3'd0,
      WALK_L1    = 3'd1,
      WALK_L2    = 3'd2,
      WALK_UPD   = 3'd3,
      WALK_DONE  = 3'd4,
      WALK_FAULT = 3'd5
   } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int AW       = 32,
   parameter int OFF_W    = 12,
   parameter int IDX_W    = 10,
   parameter int ESZ_LOG2 = 2
) (
   input  logic [AW-OFF_W-1:0] table_frame,
   input  logic [IDX_W-1:0]    index,
   output logic [AW-1:0]       entry_addr
);
   localparam int PAD_W = OFF_W - IDX_W - ESZ_LOG2;

   generate
      if (PAD_W > 0) begin : g_pad
         assign entry_addr = {table_frame, {PAD_W{1'b0}}, index, {ESZ_LOG2{1'b0}}};
      end else begin : g_nopad
         assign entry_addr = {table_frame, index, {ESZ_LOG2{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
   import ptw_pkg::*;
#(
   parameter int unsigned EW        = 32,
   parameter bit          STATUS_WB = 1'b1
) (
   input  logic [EW-1:0] entry_in,
   input  logic          is_write,
   output logic          present,
   output logic [EW-1:0] entry_out,
   output logic          wb_needed
);
   assign present = entry_in[PTE_VALID_BIT];

   generate
      if (STATUS_WB) begin : g_track
         logic [EW-1:0] set_mask;
         always_comb begin
            set_mask              = '0;
            set_mask[PTE_REF_BIT] = 1'b1;
            set_mask[PTE_MOD_BIT] = is_write;
         end
         assign entry_out = entry_in | set_mask;
         assign wb_needed = present && (entry_out != entry_in);
      end else begin : g_readonly
         logic unused_is_write;
         assign unused_is_write = is_write;
         assign entry_out       = entry_in;
         assign wb_needed       = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
   import ptw_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_fire,
   input  logic        rd_valid,
   input  logic        wr_ack,
   input  logic        entry_present,
   input  logic        wb_needed,
   output walk_state_e state
);
   walk_state_e state_nxt;

   always_comb begin
      state_nxt = state;
      unique case (state)
         WALK_IDLE:  if (req_fire) state_nxt = WALK_L1;
         WALK_L1:    if (rd_valid) state_nxt = entry_present ? WALK_L2 : WALK_FAULT;
         WALK_L2: begin
            if (rd_valid) begin
               if (!entry_present)  state_nxt = WALK_FAULT;
               else if (wb_needed)  state_nxt = WALK_UPD;
               else                 state_nxt = WALK_DONE;
            end
         end
         WALK_UPD:   if (wr_ack) state_nxt = WALK_DONE;
         WALK_DONE:  state_nxt = WALK_IDLE;
         WALK_FAULT: state_nxt = WALK_IDLE;
         default:    state_nxt = WALK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= WALK_IDLE;
      else        state <= state_nxt;
   end

   // a walk never sits in a terminal state for more than one cycle (R9)
   assert_term_leaves_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WALK_DONE || state == WALK_FAULT) |=> (state == WALK_IDLE));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int unsigned VA_W      = 32,
   parameter int unsigned PA_W      = 32,
   parameter int unsigned OFF_W     = 12,
   parameter int unsigned IDX_W     = 10,
   parameter bit          STATUS_WB = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [VA_W-1:0]       req_va,
   input  logic                  req_write,
   input  logic [PA_W-1:0]       root_base,
   output logic                  mem_rd_req,
   output logic [PA_W-1:0]       mem_rd_addr,
   input  logic                  mem_rd_valid,
   input  logic [PA_W-1:0]       mem_rd_data,
   output logic                  mem_wr_req,
   output logic [PA_W-1:0]       mem_wr_addr,
   output logic [PA_W-1:0]       mem_wr_data,
   input  logic                  mem_wr_ack,
   output logic                  done,
   output logic                  fault,
   output logic                  fault_level,
   output logic [PA_W-1:0]       pa,
   output logic [PTE_FLAG_W-1:0] flags
);
   localparam int unsigned FRAME_W = PA_W - OFF_W;
   localparam int unsigned HI_LSB  = OFF_W + IDX_W;

   // elaboration-time parameter checks
   generate
      if (VA_W != OFF_W + 2 * IDX_W) begin : g_bad_split
         $error("ptw_walker: VA_W must equal OFF_W + 2*IDX_W");
      end
      if (OFF_W < IDX_W + PTE_SIZE_LOG2) begin : g_bad_table
         $error("ptw_walker: a table must fit inside one page");
      end
      if (OFF_W <= PTE_MOD_BIT) begin : g_bad_flags
         $error("ptw_walker: status bits must sit below the frame field");
      end
      if (PA_W <= OFF_W) begin : g_bad_pa
         $error("ptw_walker: PA_W must exceed OFF_W");
      end
   endgenerate

   walk_state_e        st;
   logic [VA_W-1:0]    va_q;
   logic               wr_q;
   logic [FRAME_W-1:0] root_frame_q;
   logic [FRAME_W-1:0] l2_frame_q;
   logic [PA_W-1:0]    leaf_q;
   logic               lvl_q;

   logic               req_fire;
   logic               ent_present;
   logic               ent_wb;
   logic [PA_W-1:0]    ent_next;
   logic [PA_W-1:0]    l1_addr;
   logic [PA_W-1:0]    l2_addr;

   logic unused_root_low;
   assign unused_root_low = ^root_base[OFF_W-1:0];

   assign req_ready = (st == WALK_IDLE);
   assign req_fire  = req_valid && req_ready;

   ptw_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_fire      (req_fire),
      .rd_valid      (mem_rd_valid),
      .wr_ack        (mem_wr_ack),
      .entry_present (ent_present),
      .wb_needed     (ent_wb),
      .state         (st)
   );

   ptw_addr_gen #(
      .AW(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ESZ_LOG2(PTE_SIZE_LOG2)
   ) u_l1_addr (
      .table_frame (root_frame_q),
      .index       (va_q[HI_LSB +: IDX_W]),
      .entry_addr  (l1_addr)
   );

   ptw_addr_gen #(
      .AW(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ESZ_LOG2(PTE_SIZE_LOG2)
   ) u_l2_addr (
      .table_frame (l2_frame_q),
      .index       (va_q[OFF_W +: IDX_W]),
      .entry_addr  (l2_addr)
   );

   ptw_pte_eval #(
      .EW(PA_W), .STATUS_WB(STATUS_WB)
   ) u_eval (
      .entry_in  (mem_rd_data),
      .is_write  (wr_q),
      .present   (ent_present),
      .entry_out (ent_next),
      .wb_needed (ent_wb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_q         <= '0;
         wr_q         <= 1'b0;
         root_frame_q <= '0;
         l2_frame_q   <= '0;
         leaf_q       <= '0;
         lvl_q        <= 1'b0;
      end else begin
         if (req_fire) begin
            va_q         <= req_va;
            wr_q         <= req_write;
            root_frame_q <= root_base[PA_W-1:OFF_W];
         end
         if (st == WALK_L1 && mem_rd_valid) begin
            l2_frame_q <= mem_rd_data[PA_W-1:OFF_W];
            lvl_q      <= 1'b0;
         end
         if (st == WALK_L2 && mem_rd_valid) begin
            leaf_q <= ent_next;
            lvl_q  <= 1'b1;
         end
      end
   end

   assign mem_rd_req  = (st == WALK_L1) || (st == WALK_L2);
   assign mem_rd_addr = (st == WALK_L1) ? l1_addr : l2_addr;
   assign mem_wr_req  = (st == WALK_UPD);
   assign mem_wr_addr = l2_addr;
   assign mem_wr_data = leaf_q;

   assign done        = (st == WALK_DONE) || (st == WALK_FAULT);
   assign fault       = (st == WALK_FAULT);
   assign fault_level = (st == WALK_FAULT) && lvl_q;
   assign pa          = (st == WALK_DONE) ? {leaf_q[PA_W-1:OFF_W], va_q[OFF_W-1:0]} : '0;
   assign flags       = (st == WALK_DONE) ? leaf_q[PTE_FLAG_W-1:0] : '0;

   // a taken request makes the walker busy on the next cycle (R1)
   assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // a pending read keeps its address until served (R10)
   assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

   // a pending write keeps address and data until acknowledged (R10)
   assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_data) && $stable(mem_wr_addr)));

   // read and write port never both requested (R10)
   assert_one_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_req && mem_wr_req));

   // completion is a single-cycle pulse (R9)
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // a fault carries no physical address (R5, R6)
   assert_fault_no_pa_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> (pa == '0));

   // a written-back entry always has its referenced bit set (R7)
   assert_wb_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |-> mem_wr_data[PTE_REF_BIT]);

   // a successful walk reports a valid, referenced leaf (R4)
   assert_hit_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault) |-> (flags[PTE_VALID_BIT] && (flags[PTE_REF_BIT] || !STATUS_WB)));
endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] ROOT = 32'h0001_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic        req_write = 1'b0;
   logic [31:0] root_base = '0;
   logic        mem_rd_req;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        mem_wr_req;
   logic [31:0] mem_wr_addr;
   logic [31:0] mem_wr_data;
   logic        mem_wr_ack = 1'b0;
   logic        done;
   logic        fault;
   logic        fault_level;
   logic [31:0] pa;
   logic [2:0]  flags;

   ptw_walker u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .req_write(req_write), .root_base(root_base),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
      .done(done), .fault(fault), .fault_level(fault_level),
      .pa(pa), .flags(flags)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [31:0] mem [logic [31:0]];
   int  lat = 0;
   int  wait_cnt = 0;
   bit  resp_cycle = 0;

   bit          q_kind [$];
   logic [31:0] q_addr [$];
   logic [31:0] q_data [$];
   string       q_tag  [$];

   bit          pending = 0;
   bit          exp_fault;
   bit          exp_lvl;
   logic [31:0] exp_pa;
   logic [2:0]  exp_flags;
   string       cur_tag = "";

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rdmem(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   function automatic logic [31:0] mkva(input logic [31:0] i1, input logic [31:0] i2,
                                        input logic [31:0] off);
      return {i1[9:0], i2[9:0], off[11:0]};
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // behavioural memory with programmable latency
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_rd_valid = 0; mem_wr_ack = 0; wait_cnt = 0; resp_cycle = 0;
      end else if (resp_cycle) begin
         mem_rd_valid = 0; mem_wr_ack = 0; resp_cycle = 0; wait_cnt = 0;
      end else if (mem_rd_req || mem_wr_req) begin
         if (wait_cnt < lat) wait_cnt++;
         else begin
            resp_cycle = 1;
            check("R10 read and write not requested together",
                  {31'b0, mem_rd_req && mem_wr_req}, 32'h0);
            if (q_addr.size() == 0) begin
               check("R10 no unexpected memory access", 32'h1, 32'h0);
            end else begin
               bit          k;
               logic [31:0] a;
               logic [31:0] d;
               string       t;
               k = q_kind.pop_front(); a = q_addr.pop_front();
               d = q_data.pop_front(); t = q_tag.pop_front();
               check({t, " access kind"}, {31'b0, mem_wr_req}, {31'b0, k});
               if (mem_wr_req) begin
                  check({t, " write address"}, mem_wr_addr, a);
                  check({t, " write data"}, mem_wr_data, d);
               end else begin
                  check({t, " read address"}, mem_rd_addr, a);
               end
            end
            if (mem_wr_req) begin
               mem[mem_wr_addr] = mem_wr_data;
               mem_wr_ack = 1;
            end else begin
               mem_rd_data = rdmem(mem_rd_addr);
               mem_rd_valid = 1;
            end
         end
      end
   end

   // per-clock comparison against the model
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (rst_n) begin
         check("R1 ready tracks idle", {31'b0, req_ready}, {31'b0, !pending});
         if (done) begin
            if (!pending) begin
               check("R9 done without a walk", 32'h1, 32'h0);
            end else begin
               check({cur_tag, " R9 fault flag"}, {31'b0, fault}, {31'b0, exp_fault});
               check({cur_tag, " fault level"}, {31'b0, fault_level}, {31'b0, exp_lvl});
               check({cur_tag, " physical address"}, pa, exp_pa);
               check({cur_tag, " flags"}, {29'b0, flags}, {29'b0, exp_flags});
               check({cur_tag, " R10 all expected accesses made"}, q_addr.size(), 0);
               pending = 0;
            end
         end
      end
   end

   task automatic walk(input logic [31:0] root, input logic [31:0] va, input bit wr,
                       input string tag, input bit poke);
      logic [31:0] a1, e1, a2, e2, ne;
      a1 = {root[31:12], va[31:22], 2'b00};
      e1 = rdmem(a1);
      q_kind.push_back(0); q_addr.push_back(a1); q_data.push_back(0);
      q_tag.push_back("R2 first-level");
      exp_pa = 0; exp_flags = 0; exp_lvl = 0; exp_fault = 0;
      if (!e1[0]) begin
         exp_fault = 1; exp_lvl = 0;
      end else begin
         a2 = {e1[31:12], va[21:12], 2'b00};
         e2 = rdmem(a2);
         q_kind.push_back(0); q_addr.push_back(a2); q_data.push_back(0);
         q_tag.push_back("R3 second-level");
         if (!e2[0]) begin
            exp_fault = 1; exp_lvl = 1;
         end else begin
            ne = e2 | 32'h2 | (wr ? 32'h4 : 32'h0);
            if (ne != e2) begin
               q_kind.push_back(1); q_addr.push_back(a2); q_data.push_back(ne);
               q_tag.push_back(wr ? "R8 write-back" : "R7 write-back");
            end
            exp_pa = {ne[31:12], va[11:0]};
            exp_flags = ne[2:0];
         end
      end
      @(negedge clk);
      req_valid = 1; req_va = va; req_write = wr; root_base = root;
      pending = 1; cur_tag = tag;
      @(negedge clk);
      req_valid = 0; req_va = ~va; req_write = ~wr; root_base = ~root;
      if (poke) begin
         @(negedge clk);
         req_valid = 1; req_va = mkva(2, 0, 0); req_write = 1;
         @(negedge clk);
         req_valid = 0;
      end
      while (pending) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      // tables
      mem[ROOT + 32'd4]    = 32'h0002_0001;
      mem[ROOT + 32'd4092] = 32'h0003_0001;
      mem[32'h0002_0000 + 32'd20] = 32'h000A_B001;
      mem[32'h0002_0000 + 32'd24] = 32'h000C_D003;
      mem[32'h0002_0000 + 32'd28] = 32'h0001_2007;
      mem[32'h0002_0000 + 32'd32] = 32'h0005_5006;
      mem[32'h0003_0000 + 32'd4092] = 32'hFFFF_F001;

      repeat (3) @(negedge clk);
      check("R1 reset ready", {31'b0, req_ready}, 32'h1);
      check("R9 reset done low", {31'b0, done}, 32'h0);
      check("R10 reset no read", {31'b0, mem_rd_req}, 32'h0);
      check("R10 reset no write", {31'b0, mem_wr_req}, 32'h0);
      rst_n = 1;
      @(negedge clk);

      lat = 0;
      walk(ROOT, mkva(1, 5, 12'h123), 0, "R7 read sets referenced", 0);
      walk(ROOT, mkva(1, 5, 12'h456), 0, "R7 read already referenced", 0);
      lat = 2;
      walk(ROOT, mkva(1, 6, 12'h0AB), 1, "R8 write sets modified", 0);
      walk(ROOT, mkva(1, 7, 12'hFFF), 1, "R8 write both set", 0);
      walk(ROOT, mkva(1, 7, 12'h000), 0, "R4 read of modified page", 0);
      lat = 1;
      walk(ROOT, mkva(2, 3, 12'h010), 0, "R5 first-level fault", 0);
      walk(ROOT, mkva(0, 0, 12'h000), 1, "R5 index zero fault", 0);
      walk(ROOT, mkva(1, 8, 12'h777), 1, "R6 second-level fault", 0);
      walk(ROOT | 32'h0000_0ABC, mkva(1023, 1023, 12'hFFF), 0, "R2 R3 top index", 0);
      lat = 3;
      walk(ROOT, mkva(1, 5, 12'h321), 0, "R1 busy request ignored", 1);
      repeat (4) @(negedge clk);
      check("R1 ignored request left no walk", {31'b0, req_ready}, 32'h1);
      check("R1 ignored request made no access", q_addr.size(), 0);
      lat = 1;
      walk(ROOT, mkva(1, 5, 12'h999), 1, "R8 write on referenced page", 0);
      check("R8 stored entry", rdmem(32'h0002_0000 + 32'd20), 32'h000A_B007);
      check("R7 stored entry top", rdmem(32'h0003_0000 + 32'd4092), 32'hFFFF_F003);
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule